// File: doc/BRIEF.md
# System Clock Source Switcher

This block picks which of three oscillators drives the system clock: an external crystal (either high- or low-speed), a low-speed internal RC oscillator, or a high-speed internal RC oscillator. Software requests a switch by writing a 2-bit source code. The block accepts the request only while the write-protect unlock input is high.

When a request is accepted, the block checks the stable flag of the target oscillator. If the target is stable, the switch happens. If it is not stable, the active source is kept and a sticky fail flag is raised. Software clears that flag by writing 1 to it.

A 4-bit divide value sets how often a clock-enable pulse fires, counted in cycles of the selected source. The actual clock multiplexing is modelled as a plain synchronous change of the select value. The divided clock is modelled as a periodic enable pulse.

Writes use a small register interface:

| Address | Field | Effect |
|---|---|---|
| 0 | `wr_data[1:0]` | Source select |
| 1 | `wr_data[3:0]` | Divide value |
| 2 | `wr_data[7]` | Writing 1 clears the fail flag |

Top module: `sysclk_switcher`

## Requirements
- R1: After reset the active source is 00 (crystal), the fail flag is 0 and the divide value is 0, so `div_tick` is high on every cycle.
- R2: A write to address 0 while `unlock` is high, with a target whose stable input is high, sets `src_active` to the written code and clears the fail flag on the next cycle. The codes are 00 crystal, 01 low-speed RC and 11 high-speed RC.
- R3: The same unlocked select write with a target whose stable input is low sets the fail flag (status bit 7) to 1 and leaves `src_active` unchanged.
- R4: A write to address 2 with `wr_data[7]`=1 clears the fail flag. A write to address 2 with `wr_data[7]`=0 leaves it unchanged.
- R5: Code 10 is not a valid source. An unlocked write of 10 sets the fail flag, and `src_active` never takes the value 10.
- R6: A select write while `unlock` is low changes neither `src_active` nor the fail flag.
- R7: `status` carries the crystal stable input at bit 0, the low-speed RC stable input at bit 3, the high-speed RC stable input at bit 4 and the fail flag at bit 7. All other bits are 0.
- R8: With divide value N (written to address 1 as `wr_data[3:0]`), `div_tick` pulses once every N+1 cycles.
- R9: A new divide value takes effect only after the next terminal count. The period in progress completes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the selected source (modelled) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 select, 1 divide, 2 status clear |
| wr_data | input | 8 | Write data |
| unlock | input | 1 | Write-protect unlock; must be high for select writes |
| xtal_ok | input | 1 | Crystal stable flag |
| lirc_ok | input | 1 | Low-speed RC stable flag |
| hirc_ok | input | 1 | High-speed RC stable flag |
| src_active | output | 2 | Currently active source code |
| div_tick | output | 1 | Divided clock-enable pulse |
| status | output | 8 | Stable flags and sticky fail flag |

## Verification
A wrong source register shows on `src_active` one cycle after the offending write. A wrong fail flag shows at the same point on `status` bit 7. Either error stays visible until the next accepted select write or clear.

A corrupted divide counter or pending value shows as a wrong `div_tick` spacing. That error is visible within at most one full period (16 cycles at the largest divide value). A premature reload shows as a shortened period, measured right after the divide write.

// File: rtl/sysclk_switcher.sv
module sysclk_switcher #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             unlock,
  input  logic             xtal_ok,
  input  logic             lirc_ok,
  input  logic             hirc_ok,
  output logic [1:0]       src_active,
  output logic             div_tick,
  output logic [7:0]       status
);

  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_DIV = 2'd1;
  localparam logic [1:0] A_STS = 2'd2;

  logic             fail_q;
  logic             target_ok;
  logic [DIV_W-1:0] div_pend, div_act, cnt;

  wire sel_wr = wr_en && (wr_addr == A_SEL) && unlock;
  wire clr_wr = wr_en && (wr_addr == A_STS) && wr_data[7];
  wire div_wr = wr_en && (wr_addr == A_DIV);

  always_comb begin
    case (wr_data[1:0])
      2'b00:   target_ok = xtal_ok;
      2'b01:   target_ok = lirc_ok;
      2'b11:   target_ok = hirc_ok;
      default: target_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_active <= 2'b00;
      fail_q     <= 1'b0;
    end else if (sel_wr) begin
      fail_q <= !target_ok;
      if (target_ok) src_active <= wr_data[1:0];
    end else if (clr_wr) begin
      fail_q <= 1'b0;
    end
  end

  assign div_tick = (cnt == div_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pend <= '0;
      div_act  <= '0;
      cnt      <= '0;
    end else begin
      if (div_wr) div_pend <= wr_data[DIV_W-1:0];
      if (div_tick) begin
        cnt     <= '0;
        div_act <= div_pend;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign status = {fail_q, 2'b00, hirc_ok, lirc_ok, 2'b00, xtal_ok};

endmodule

// File: rtl/sysclk_switcher_chk.sv
module sysclk_switcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       unlock,
  input logic       hirc_ok,
  input logic       lirc_ok,
  input logic [1:0] src_active,
  input logic [7:0] status
);

  wire sel_try = wr_en && (wr_addr == 2'd0) && unlock;

  AST_SRC_NEVER_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    src_active != 2'b10); // R5

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_try |=> $stable(src_active)); // R6

  AST_FAIL_ON_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_try && wr_data[1:0] == 2'b01 && !lirc_ok |=> status[7] && $stable(src_active)); // R3

  AST_SWITCH_HIRC: assert property (@(posedge clk) disable iff (!rst_n)
    sel_try && wr_data[1:0] == 2'b11 && hirc_ok |=> src_active == 2'b11 && !status[7]); // R2

  AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 2'd2 && wr_data[7] |=> !status[7]); // R4

endmodule

bind sysclk_switcher sysclk_switcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .unlock(unlock), .hirc_ok(hirc_ok), .lirc_ok(lirc_ok),
  .src_active(src_active), .status(status)
);

// File: tb/sim_sysclk_switcher.sv
module sim_sysclk_switcher;
  logic clk = 0, rst_n = 0, wr_en = 0, unlock = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic xtal_ok = 1, lirc_ok = 0, hirc_ok = 1;
  logic [1:0] src_active;
  logic div_tick;
  logic [7:0] status;

  always #2 clk = ~clk;

  sysclk_switcher u0 (.*);

  typedef struct {
    int         kind;
    int         req;
    logic [1:0] src;
    logic [7:0] st;
    int         period;
  } item_t;

  item_t q[$];
  int vectors = 0, errors = 0;
  bit busy = 0, done = 0;

  task automatic push_state(int req, logic [1:0] s, logic [7:0] st);
    item_t it;
    it.kind = 0; it.req = req; it.src = s; it.st = st; it.period = 0;
    q.push_back(it);
    wait (q.size() == 0 && !busy);
  endtask

  task automatic push_period(int req, int p);
    item_t it;
    it.kind = 1; it.req = req; it.src = 0; it.st = 0; it.period = p;
    q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d, logic u);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; unlock = u;
    @(posedge clk);
    #1 wr_en = 0; unlock = 0;
  endtask

  task automatic to_tick();
    do @(negedge clk); while (!div_tick);
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      busy = 1;
      it = q.pop_front();
      if (it.kind == 0) begin
        @(negedge clk);
        vectors++;
        if (src_active !== it.src || status !== it.st) begin
          errors++;
          $display("FAIL R%0d: src=%b status=%h expected src=%b status=%h",
                   it.req, src_active, status, it.src, it.st);
        end
      end else begin
        int n;
        n = 0;
        do begin @(negedge clk); n++; end while (!div_tick && n < 100);
        vectors++;
        if (n != it.period) begin
          errors++;
          $display("FAIL R%0d: tick distance=%0d expected %0d", it.req, n, it.period);
        end
      end
      busy = (q.size() > 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    push_state(1, 2'b00, 8'h11);            // R1 reset state, R7 layout
    to_tick(); push_period(1, 1);           // R1 tick every cycle
    wait (q.size() == 0 && !busy);

    wr(2'd0, 8'h03, 1); push_state(2, 2'b11, 8'h11);  // R2 switch to high RC
    wr(2'd0, 8'h01, 1); push_state(3, 2'b11, 8'h91);  // R3 low RC unstable
    wr(2'd2, 8'h00, 0); push_state(4, 2'b11, 8'h91);  // R4 bit7=0 keeps flag
    wr(2'd2, 8'h80, 0); push_state(4, 2'b11, 8'h11);  // R4 clear
    wr(2'd0, 8'h02, 1); push_state(5, 2'b11, 8'h91);  // R5 reserved code fails
    wr(2'd0, 8'h00, 0); push_state(6, 2'b11, 8'h91);  // R6 locked write ignored
    wr(2'd0, 8'h00, 1); push_state(2, 2'b00, 8'h11);  // R2 success clears fail

    @(negedge clk); xtal_ok = 0; lirc_ok = 1; hirc_ok = 0;
    push_state(7, 2'b00, 8'h08);                      // R7 status mirrors inputs
    wr(2'd0, 8'h01, 1); push_state(2, 2'b01, 8'h08);  // R2 switch to low RC
    wr(2'd0, 8'h03, 1); push_state(3, 2'b01, 8'h88);  // R3 high RC unstable

    wr(2'd1, 8'h03, 0);
    repeat (40) @(negedge clk);
    to_tick(); push_period(8, 4); push_period(8, 4);  // R8 N=3
    wait (q.size() == 0 && !busy);

    wr(2'd1, 8'h0F, 0);
    repeat (40) @(negedge clk);
    to_tick(); push_period(8, 16);                    // R8 N=15
    wait (q.size() == 0 && !busy);

    to_tick();
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h01, 0);
    push_period(9, 13);                               // R9 old period completes
    push_period(9, 2);                                // R9 new value after terminal
    wait (q.size() == 0 && !busy);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule